// File: doc/BRIEF.md
# Address Lookup Engine Control and Interrupt Registers

This block is the register and control front end of a 24-port switch address-lookup engine. A host processor reaches it over a byte-wide register bus. It drives feature-disable and hash-select controls into the lookup core and gates address learning per port. It generates the periodic aging tick. It collects core events into a sticky interrupt source register, which a mask register reduces to one interrupt line.

At reset, strap inputs are captured into a startup register. A small sequencer then runs the boot order. It starts on its own, or it waits for a start command from the host. It runs an optional self-test phase and then an initialization phase, and it enters normal running when initialization is reported done.

The register bus is plain. Each write strobe is accepted in the cycle it is presented, and there is no back-pressure. Read data is a combinational function of the address. Core events are single-cycle pulses with no handshake.

Top module: `lkup_ctl_regs`

## Requirements
- R1: While `rst_n` is low at a clock edge, all registers clear: configuration, mask, sources and period are 0, and every `learn_en` bit is 1. The startup register (address 0x8) instead takes `boot_strap`.
- R2: Configuration register, address 0x0: bit 0 drives `age_off`, bit 1 drives `lookup_off`, bit 2 drives `dst_cache_off`, bit 3 drives `src_cache_off`, and bits 7:4 drive `hash_sel`. Every register reads back on `reg_rdata` in the cycle after its write.
- R3: Interrupt source register, address 0x1. Bit 0 is an aged address, bit 1 a new address, bit 4 a bucket overflow, bit 5 command done, bit 6 initialization complete and bit 7 self-test failure. Bits 2 and 3 always read 0. A bit is set by its event pulse and stays set until a write with a 1 in that bit. An event and a clear in the same cycle leave the bit set.
- R4: `irq` is high exactly when some source bit and the same bit of the mask register (address 0x2) are both 1.
- R5: Learning-disable bytes sit at addresses 0x3, 0x4 and 0x5 and cover ports 0-7, 8-15 and 16-23, with the low bit for the lowest port. A set bit drives that port's `learn_en` low.
- R6: The aging period is a 16-bit value, with the low byte at address 0x6 and the high byte at address 0x7. A write to either byte restarts the timer. With period P, `age_tick` pulses for one cycle every P×2^PRE_W cycles. The first pulse comes P×2^PRE_W cycles after the write edge.
- R7: `age_tick` stays low while `age_off` is 1 or the period is 0.
- R8: Startup register bits: bit 3 is self-test enable, bit 2 is production test (driven on `prod_test`), bit 1 is CPU-absent and bit 0 is CPU-ready. If bit 1 or bit 0 is set, the boot order starts by itself. Otherwise it waits until 0x01 is written to the command register at address 0x9; any other command value is ignored.
- R9: When started, the sequencer raises `bist_run` if self test is enabled; otherwise it raises `init_run` directly. `bist_done` moves it to initialization, and `bist_fail` together with `bist_done` sets source bit 7. `init_done` in the initialization phase sets source bit 6 and raises `sys_run`, which then stays high. At most one of the three phase outputs is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| boot_strap | input | 4 | Strap levels captured during reset |
| evt_aged | input | 1 | Aged-address event pulse |
| evt_new | input | 1 | New-address event pulse |
| evt_ovf | input | 1 | Bucket-overflow event pulse |
| evt_cmd_done | input | 1 | Command-done event pulse |
| bist_done | input | 1 | Self test finished |
| bist_fail | input | 1 | Self-test result, valid with `bist_done` |
| init_done | input | 1 | Initialization finished |
| age_off | output | 1 | Aging disabled |
| lookup_off | output | 1 | Lookup disabled |
| dst_cache_off | output | 1 | Destination-address cache disabled |
| src_cache_off | output | 1 | Source-address cache disabled |
| hash_sel | output | 4 | Hash algorithm select |
| learn_en | output | 24 | Per-port learning enable |
| age_tick | output | 1 | One-cycle aging period pulse |
| irq | output | 1 | Interrupt request |
| bist_run | output | 1 | Self-test phase active |
| init_run | output | 1 | Initialization phase active |
| sys_run | output | 1 | Normal running |
| prod_test | output | 1 | Production test mode |

## Verification
A register write, an event pulse or a sequencer move shows on the outputs one clock edge after it is presented. `irq` and `reg_rdata` follow combinationally from that registered state. The bench drives at the falling edge and samples at the next falling edge, so each check falls in the first cycle the result is due. With a 3-bit prescaler, aging ticks are due 8×P edges after the period write. The bench therefore counts ticks over a fixed 60-cycle window from the write: 3 ticks for P=2, 7 ticks for P=1, and 0 when aging is suppressed.

// File: rtl/lkup_pkg.sv
package lkup_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] A_CFG    = 4'h0;
  localparam logic [REG_AW-1:0] A_ISRC   = 4'h1;
  localparam logic [REG_AW-1:0] A_IMSK   = 4'h2;
  localparam logic [REG_AW-1:0] A_LRN0   = 4'h3;
  localparam logic [REG_AW-1:0] A_AGE_LO = 4'h6;
  localparam logic [REG_AW-1:0] A_AGE_HI = 4'h7;
  localparam logic [REG_AW-1:0] A_BOOT   = 4'h8;
  localparam logic [REG_AW-1:0] A_CMD    = 4'h9;
  localparam logic [7:0] CMD_START = 8'h01;

  // interrupt source bit positions
  localparam int SB_AGED = 0;
  localparam int SB_NEW  = 1;
  localparam int SB_OVF  = 4;
  localparam int SB_CMD  = 5;
  localparam int SB_INIT = 6;
  localparam int SB_BIST = 7;
  localparam logic [7:0] SRC_RSVD = 8'h0C;

  // startup register bit positions
  localparam int BT_GO    = 0;
  localparam int BT_NOCPU = 1;
  localparam int BT_PTEST = 2;
  localparam int BT_STEST = 3;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_WAIT, SQ_BIST, SQ_INIT, SQ_RUN
  } seq_t;
endpackage

// File: rtl/lkup_irq_ctl.sv
module lkup_irq_ctl #(
  parameter int W = 8,
  parameter logic [W-1:0] RSVD = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic         clr_we,
  input  logic [W-1:0] clr_vec,
  input  logic [W-1:0] mask,
  output logic [W-1:0] src,
  output logic         irq
);
  logic [W-1:0] pend;

  for (genvar b = 0; b < W; b++) begin : g_bit
    if (RSVD[b]) begin : g_rsvd
      assign src[b] = 1'b0;
    end else begin : g_live
      logic bit_q;
      always_ff @(posedge clk) begin
        if (!rst_n)          bit_q <= 1'b0;
        else if (set_vec[b]) bit_q <= 1'b1;             // set beats clear
        else if (clr_we && clr_vec[b]) bit_q <= 1'b0;
      end
      assign src[b] = bit_q;
    end
  end

  assign pend = src & mask;
  assign irq  = |pend;
endmodule

// File: rtl/lkup_age_timer.sv
module lkup_age_timer #(
  parameter int PRE_W = 28,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             load,
  input  logic [PER_W-1:0] load_val,
  input  logic [PER_W-1:0] period,
  output logic             tick
);
  logic [PRE_W-1:0] pre_cnt;
  logic [PER_W-1:0] unit_cnt;
  logic             unit_end;
  logic             last_unit;

  assign unit_end  = &pre_cnt;
  assign last_unit = (unit_cnt == PER_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n || load) pre_cnt <= '0;
    else                pre_cnt <= pre_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      unit_cnt <= '0;
    else if (load)
      unit_cnt <= load_val;
    else if (unit_end) begin
      if (unit_cnt <= PER_W'(1)) unit_cnt <= period;
      else                       unit_cnt <= unit_cnt - 1'b1;
    end
  end

  assign tick = enable && (period != '0) && unit_end && last_unit && !load;
endmodule

// File: rtl/lkup_start_seq.sv
module lkup_start_seq
  import lkup_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic self_test_en,
  input  logic cpu_absent,
  input  logic cpu_ready,
  input  logic start_cmd,
  input  logic bist_done,
  input  logic bist_fail,
  input  logic init_done,
  output logic bist_run,
  output logic init_run,
  output logic sys_run,
  output logic ev_init_ok,
  output logic ev_bist_bad
);
  seq_t st_q, st_d;
  logic go;

  assign go = cpu_absent | cpu_ready | start_cmd;

  always_comb begin
    st_d = st_q;
    case (st_q)
      SQ_IDLE, SQ_WAIT: begin
        if (go)                st_d = self_test_en ? SQ_BIST : SQ_INIT;
        else if (st_q == SQ_IDLE) st_d = SQ_WAIT;
      end
      SQ_BIST: if (bist_done) st_d = SQ_INIT;
      SQ_INIT: if (init_done) st_d = SQ_RUN;
      SQ_RUN:  st_d = SQ_RUN;
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= SQ_IDLE;
    else        st_q <= st_d;
  end

  assign bist_run    = (st_q == SQ_BIST);
  assign init_run    = (st_q == SQ_INIT);
  assign sys_run     = (st_q == SQ_RUN);
  assign ev_bist_bad = bist_run & bist_done & bist_fail;
  assign ev_init_ok  = init_run & init_done;
endmodule

// File: rtl/lkup_ctl_regs.sv
module lkup_ctl_regs
  import lkup_pkg::*;
#(
  parameter int NUM_PORTS = 24,
  parameter int PRE_W     = 28,
  parameter int PER_W     = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [7:0]           reg_wdata,
  output logic [7:0]           reg_rdata,
  input  logic [3:0]           boot_strap,
  input  logic                 evt_aged,
  input  logic                 evt_new,
  input  logic                 evt_ovf,
  input  logic                 evt_cmd_done,
  input  logic                 bist_done,
  input  logic                 bist_fail,
  input  logic                 init_done,
  output logic                 age_off,
  output logic                 lookup_off,
  output logic                 dst_cache_off,
  output logic                 src_cache_off,
  output logic [3:0]           hash_sel,
  output logic [NUM_PORTS-1:0] learn_en,
  output logic                 age_tick,
  output logic                 irq,
  output logic                 bist_run,
  output logic                 init_run,
  output logic                 sys_run,
  output logic                 prod_test
);
  localparam int LRN_BYTES = NUM_PORTS / 8;

  logic [7:0]           cfg_q, imsk_q, age_lo_q, age_hi_q;
  logic [3:0]           boot_q;
  logic [NUM_PORTS-1:0] lrn_off_q;
  logic [7:0]           isrc;
  logic [7:0]           set_vec;
  logic [PER_W-1:0]     period, load_val;
  logic                 wr_cfg, wr_imsk, wr_isrc, wr_lo, wr_hi, start_cmd;
  logic                 ev_init_ok, ev_bist_bad;

  assign wr_cfg    = reg_wr && (reg_addr == A_CFG);
  assign wr_imsk   = reg_wr && (reg_addr == A_IMSK);
  assign wr_isrc   = reg_wr && (reg_addr == A_ISRC);
  assign wr_lo     = reg_wr && (reg_addr == A_AGE_LO);
  assign wr_hi     = reg_wr && (reg_addr == A_AGE_HI);
  assign start_cmd = reg_wr && (reg_addr == A_CMD) && (reg_wdata == CMD_START);

  // plain byte registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      imsk_q   <= '0;
      age_lo_q <= '0;
      age_hi_q <= '0;
      boot_q   <= boot_strap;
    end else begin
      if (wr_cfg)  cfg_q    <= reg_wdata;
      if (wr_imsk) imsk_q   <= reg_wdata;
      if (wr_lo)   age_lo_q <= reg_wdata;
      if (wr_hi)   age_hi_q <= reg_wdata;
    end
  end

  // learning-disable bytes, one per group of eight ports
  always_ff @(posedge clk) begin
    if (!rst_n) lrn_off_q <= '0;
    else begin
      for (int b = 0; b < LRN_BYTES; b++)
        if (reg_wr && (reg_addr == REG_AW'(int'(A_LRN0) + b)))
          lrn_off_q[b*8 +: 8] <= reg_wdata;
    end
  end

  assign learn_en      = ~lrn_off_q;
  assign age_off       = cfg_q[0];
  assign lookup_off    = cfg_q[1];
  assign dst_cache_off = cfg_q[2];
  assign src_cache_off = cfg_q[3];
  assign hash_sel      = cfg_q[7:4];
  assign prod_test     = boot_q[BT_PTEST];

  // read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:    reg_rdata = cfg_q;
      A_ISRC:   reg_rdata = isrc;
      A_IMSK:   reg_rdata = imsk_q;
      A_AGE_LO: reg_rdata = age_lo_q;
      A_AGE_HI: reg_rdata = age_hi_q;
      A_BOOT:   reg_rdata = {4'b0000, boot_q};
      default:  reg_rdata = '0;
    endcase
    for (int b = 0; b < LRN_BYTES; b++)
      if (reg_addr == REG_AW'(int'(A_LRN0) + b))
        reg_rdata = lrn_off_q[b*8 +: 8];
  end

  // interrupt sources
  always_comb begin
    set_vec          = '0;
    set_vec[SB_AGED] = evt_aged;
    set_vec[SB_NEW]  = evt_new;
    set_vec[SB_OVF]  = evt_ovf;
    set_vec[SB_CMD]  = evt_cmd_done;
    set_vec[SB_INIT] = ev_init_ok;
    set_vec[SB_BIST] = ev_bist_bad;
  end

  lkup_irq_ctl #(.W(8), .RSVD(SRC_RSVD)) u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_we  (wr_isrc),
    .clr_vec (reg_wdata),
    .mask    (imsk_q),
    .src     (isrc),
    .irq     (irq)
  );

  // aging timer, reloaded with the value being written
  assign period   = PER_W'({age_hi_q, age_lo_q});
  assign load_val = wr_lo ? PER_W'({age_hi_q, reg_wdata}) : PER_W'({reg_wdata, age_lo_q});

  lkup_age_timer #(.PRE_W(PRE_W), .PER_W(PER_W)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (!age_off),
    .load     (wr_lo | wr_hi),
    .load_val (load_val),
    .period   (period),
    .tick     (age_tick)
  );

  lkup_start_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .self_test_en (boot_q[BT_STEST]),
    .cpu_absent   (boot_q[BT_NOCPU]),
    .cpu_ready    (boot_q[BT_GO]),
    .start_cmd    (start_cmd),
    .bist_done    (bist_done),
    .bist_fail    (bist_fail),
    .init_done    (init_done),
    .bist_run     (bist_run),
    .init_run     (init_run),
    .sys_run      (sys_run),
    .ev_init_ok   (ev_init_ok),
    .ev_bist_bad  (ev_bist_bad)
  );
endmodule

// File: rtl/lkup_ctl_regs_chk.sv
module lkup_ctl_regs_chk
  import lkup_pkg::*;
#(
  parameter int NUM_PORTS = 24
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [REG_AW-1:0]    reg_addr,
  input logic                 reg_wr,
  input logic [7:0]           reg_wdata,
  input logic                 evt_aged,
  input logic                 init_done,
  input logic [7:0]           isrc,
  input logic                 irq,
  input logic                 age_off,
  input logic                 age_tick,
  input logic [NUM_PORTS-1:0] learn_en,
  input logic                 bist_run,
  input logic                 init_run,
  input logic                 sys_run
);
  a_r3_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt_aged |=> isrc[SB_AGED]);

  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (isrc[SB_AGED] && !(reg_wr && reg_addr == A_ISRC && reg_wdata[SB_AGED])) |=> isrc[SB_AGED]);

  a_r4_mask_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_IMSK && reg_wdata == 8'h00) |=> !irq);

  a_r5_learn_byte0: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == A_LRN0) |=> (learn_en[7:0] == ~$past(reg_wdata)));

  a_r7_age_off: assert property (@(posedge clk) disable iff (!rst_n)
    age_off |-> !age_tick);

  a_r9_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bist_run, init_run, sys_run}));

  a_r9_run_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_run) |-> $past(init_done));

  a_r9_run_holds: assert property (@(posedge clk) disable iff (!rst_n)
    sys_run |=> sys_run);
endmodule

bind lkup_ctl_regs lkup_ctl_regs_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_addr  (reg_addr),
  .reg_wr    (reg_wr),
  .reg_wdata (reg_wdata),
  .evt_aged  (evt_aged),
  .init_done (init_done),
  .isrc      (isrc),
  .irq       (irq),
  .age_off   (age_off),
  .age_tick  (age_tick),
  .learn_en  (learn_en),
  .bist_run  (bist_run),
  .init_run  (init_run),
  .sys_run   (sys_run)
);

// File: tb/lkup_ctl_regs_test.sv
module lkup_ctl_regs_test;
  localparam int NP = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic [7:0]    reg_rdata;
  logic [3:0]    boot_strap = '0;
  logic          evt_aged = 0, evt_new = 0, evt_ovf = 0, evt_cmd_done = 0;
  logic          bist_done = 0, bist_fail = 0, init_done = 0;
  logic          age_off, lookup_off, dst_cache_off, src_cache_off;
  logic [3:0]    hash_sel;
  logic [NP-1:0] learn_en;
  logic          age_tick, irq, bist_run, init_run, sys_run, prod_test;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lkup_ctl_regs #(.NUM_PORTS(NP), .PRE_W(3), .PER_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .boot_strap(boot_strap),
    .evt_aged(evt_aged), .evt_new(evt_new), .evt_ovf(evt_ovf),
    .evt_cmd_done(evt_cmd_done), .bist_done(bist_done), .bist_fail(bist_fail),
    .init_done(init_done), .age_off(age_off), .lookup_off(lookup_off),
    .dst_cache_off(dst_cache_off), .src_cache_off(src_cache_off),
    .hash_sel(hash_sel), .learn_en(learn_en), .age_tick(age_tick), .irq(irq),
    .bist_run(bist_run), .init_run(init_run), .sys_run(sys_run),
    .prod_test(prod_test)
  );

  // {addr, wdata, expected readback}
  localparam logic [19:0] VEC [8] = '{
    {4'h0, 8'hA5, 8'hA5},
    {4'h2, 8'hF3, 8'hF3},
    {4'h3, 8'h0F, 8'h0F},
    {4'h4, 8'h80, 8'h80},
    {4'h5, 8'h01, 8'h01},
    {4'h6, 8'h34, 8'h34},
    {4'h7, 8'h12, 8'h12},
    {4'h1, 8'hFF, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset(input logic [3:0] s);
    rst_n = 1'b0; boot_strap = s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic count_ticks(output int n);
    n = 0;
    for (int i = 0; i < 60; i++) begin
      if (age_tick) n++;
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int n;
    @(negedge clk);

    // Scenario A: CPU present, must wait for command, no self test
    do_reset(4'b0000);
    rd(4'h0, d); chk("R1 cfg reset", d, 8'h00);
    chk("R1 hash_sel reset", hash_sel, 4'h0);
    rd(4'h1, d); chk("R1 src reset", d, 8'h00);
    rd(4'h2, d); chk("R1 mask reset", d, 8'h00);
    rd(4'h6, d); chk("R1 period reset", d, 8'h00);
    rd(4'h8, d); chk("R1 strap capture", d, 8'h00);
    chk("R1 learn_en reset", learn_en, 24'hFFFFFF);
    chk("R8 waits for command", {bist_run, init_run, sys_run}, 3'b000);

    // vector table walk (R2 readback, R3 clear on empty, R5 bytes)
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][19:16], VEC[i][15:8]);
      rd(VEC[i][19:16], d);
      chk($sformatf("R2 readback row %0d", i), d, VEC[i][7:0]);
    end
    chk("R2 hash_sel", hash_sel, 4'hA);
    chk("R2 disable bits", {src_cache_off, dst_cache_off, lookup_off, age_off}, 4'b0101);
    chk("R5 learn_en per port", learn_en, 24'hFE7FF0);
    chk("R4 irq with no source", irq, 1'b0);
    wr(4'h0, 8'h00); wr(4'h2, 8'h00);

    // R3 events, clear, reserved bits, set wins over clear
    evt_aged = 1; evt_ovf = 1; @(negedge clk); evt_aged = 0; evt_ovf = 0;
    rd(4'h1, d); chk("R3 events set", d, 8'h11);
    wr(4'h1, 8'h01);
    rd(4'h1, d); chk("R3 write-1 clear", d, 8'h10);
    wr(4'h2, 8'h10);
    chk("R4 irq masked source", irq, 1'b1);
    wr(4'h2, 8'hEF);
    chk("R4 irq other mask bits", irq, 1'b0);
    wr(4'h2, 8'h10); wr(4'h1, 8'h10);
    chk("R4 irq after clear", irq, 1'b0);
    evt_new = 1; reg_addr = 4'h1; reg_wdata = 8'h02; reg_wr = 1;
    @(negedge clk); evt_new = 0; reg_wr = 0;
    evt_cmd_done = 1; @(negedge clk); evt_cmd_done = 0;
    rd(4'h1, d); chk("R3 set wins, reserved zero", d, 8'h22);
    wr(4'h1, 8'hFF); wr(4'h2, 8'h00);

    // R6/R7 aging
    wr(4'h7, 8'h00); wr(4'h6, 8'h02);
    count_ticks(n); chk("R6 ticks period 2", n, 3);
    wr(4'h6, 8'h01);
    count_ticks(n); chk("R6 ticks period 1", n, 7);
    wr(4'h0, 8'h01); wr(4'h6, 8'h02);
    count_ticks(n); chk("R7 ticks with aging off", n, 0);
    wr(4'h0, 8'h00); wr(4'h6, 8'h00);
    count_ticks(n); chk("R7 ticks with period 0", n, 0);

    // R8/R9 start by command
    wr(4'h9, 8'h02);
    chk("R8 wrong command ignored", {bist_run, init_run, sys_run}, 3'b000);
    wr(4'h9, 8'h01);
    chk("R8 start command", {bist_run, init_run, sys_run}, 3'b010);
    init_done = 1; @(negedge clk); init_done = 0;
    chk("R9 run after init", {bist_run, init_run, sys_run}, 3'b001);
    rd(4'h1, d); chk("R9 init complete source", d, 8'h40);

    // Scenario B: no CPU, self test enabled
    do_reset(4'b1010);
    rd(4'h8, d); chk("R1 strap capture B", d, 8'h0A);
    chk("R8 prod_test low", prod_test, 1'b0);
    chk("R9 self test starts alone", {bist_run, init_run, sys_run}, 3'b100);
    bist_done = 1; bist_fail = 1; @(negedge clk); bist_done = 0; bist_fail = 0;
    chk("R9 init after self test", {bist_run, init_run, sys_run}, 3'b010);
    rd(4'h1, d); chk("R9 self-test fail source", d, 8'h80);

    // Scenario C: CPU ready strap, production test
    do_reset(4'b0101);
    chk("R8 prod_test high", prod_test, 1'b1);
    chk("R8 CPU-ready starts, self test skipped", {bist_run, init_run, sys_run}, 3'b010);

    finish_run();
  end
endmodule